// File: doc/BRIEF.md
# Two-Pass Staged Byte Mover

This block is a small DMA engine that moves bytes between system memory and one of two FIFOs. One FIFO feeds the video output. The other talks to the host interface. A CPU sets it up through a byte-wide register port with a base address, a byte count, and a control word giving direction, FIFO choice, addressing mode and a bank bit. It then raises the enable bit. The engine requests the memory bus and, once granted, moves one byte every two clocks. The first clock moves the data. The second steps the counters and checks for terminal count.

A memory-to-memory copy is done in two runs. The first run loads memory into a FIFO. The second run empties that FIFO into memory at the new address. Because every byte is held in the FIFO before it is written back, source and destination may overlap. Each run picks its own addressing mode, linear or rectangular. So a block can be loaded linearly and written as a rectangle.

If the source FIFO is empty or the destination FIFO is full, the run stops without moving a byte and sets an error flag. The remaining count and the hidden pointer are kept, so raising enable again carries on from the byte that stopped. Both normal completion and an abort hold the interrupt until the CPU reads the control register.

Top module: `blit_dma`

## Requirements
- R1: After reset all registers read zero, `irq_o` and `mem_req_o` are low, and no FIFO or memory strobe is active.
- R2: Register map at `reg_addr_i`:
  - 0 is control/status: bit0 enable, bit1 direction (0 memory to FIFO, 1 FIFO to memory), bit2 FIFO select (0 video, 1 interface), bit3 rectangular, bit4 bank, read-only bit5 done, read-only bit6 error.
  - 1 and 2 are the base address low and high bytes.
  - 3 is the byte count.
  - 4 is the row width.
  - 5 and 6 are the stride low and high bytes.
  - The writable fields read back as written.
- R3: In a memory-to-FIFO run, the engine pushes the byte at `mem_rdata_i` into the selected FIFO. This happens at memory addresses base, base+1, and so on in linear mode, with one push every 2 clocks.
- R4: In a FIFO-to-memory run, the engine pops the selected FIFO and writes the popped byte to memory, in the same cycle, at the stepped addresses.
- R5: The count drops by one per byte. After the last byte the done flag is set, enable reads 0, `irq_o` is high and the count reads 0.
- R6: If the source FIFO is empty or the destination FIFO is full when a byte is due, the run stops without moving it. The error flag is then set, enable clears and the count keeps the bytes still to move. Re-enabling continues at the next unmoved address.
- R7: `irq_o` stays high until the control register is read. That read returns the done and error flags and then clears both.
- R8: In rectangular mode, the pointer advances by the stride after each run of width bytes, and by one otherwise.
- R9: `mem_addr_o` bit 16 carries the bank bit. Bits 15:0 carry base plus pointer.
- R10: Without `mem_gnt_i`, the engine keeps `mem_req_o` high and makes no memory or FIFO access.
- R11: Enabling with a count of zero sets done and raises the interrupt without any access.
- R12: The hidden pointer returns to zero on a write to either base address byte and on normal completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears flags on control read) |
| reg_rdata_o | output | 8 | Register read data |
| mem_req_o | output | 1 | Bus request |
| mem_gnt_i | input | 1 | Bus grant |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 17 | Memory address, bank bit on top |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the access cycle |
| fifo_wdata_o | output | 8 | Data pushed to either FIFO |
| vid_push_o | output | 1 | Push to video FIFO |
| vid_full_i | input | 1 | Video FIFO full |
| vid_pop_o | output | 1 | Pop from video FIFO |
| vid_empty_i | input | 1 | Video FIFO empty |
| vid_rdata_i | input | 8 | Video FIFO head data |
| ifc_push_o | output | 1 | Push to interface FIFO |
| ifc_full_i | input | 1 | Interface FIFO full |
| ifc_pop_o | output | 1 | Pop from interface FIFO |
| ifc_empty_i | input | 1 | Interface FIFO empty |
| ifc_rdata_i | input | 8 | Interface FIFO head data |
| irq_o | output | 1 | Interrupt, held until control read |

## Verification
The bench builds the block with its default parameters: 16-bit address, 8-bit count and width, and 8-bit data. With these, the bank bit sits on bit 16 and counts of a few bytes reach terminal count quickly. A rectangle of width 3 with stride 10 crosses two row ends within seven bytes. Abort and resume are reached by raising a FIFO flag between two bytes of a run. This shows that the count and pointer survive the stop.

// File: rtl/blit_dma_pkg.sv
package blit_dma_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] RA_CTRL      = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE_LO   = 3'd1;
  localparam logic [REG_AW-1:0] RA_BASE_HI   = 3'd2;
  localparam logic [REG_AW-1:0] RA_COUNT     = 3'd3;
  localparam logic [REG_AW-1:0] RA_WIDTH     = 3'd4;
  localparam logic [REG_AW-1:0] RA_STRIDE_LO = 3'd5;
  localparam logic [REG_AW-1:0] RA_STRIDE_HI = 3'd6;

  typedef struct packed {
    logic bank;
    logic rect;
    logic sel;
    logic dir;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MOVE   = 2'd1,
    ST_UPDATE = 2'd2
  } state_t;
endpackage

// File: rtl/blit_dma_regs.sv
module blit_dma_regs
  import blit_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic              step_i,
  input  logic              done_set_i,
  input  logic              err_set_i,
  output logic [REG_DW-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  width_o,
  output logic              ptr_clr_o,
  output logic              irq_o
);
  localparam int HI_W = ADDR_W - 8;

  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] base_q, stride_q;
  logic [CNT_W-1:0]  count_q, width_q;
  logic              done_q, err_q;
  logic              rd_ctrl;

  assign rd_ctrl = rd_i && (addr_i == RA_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      base_q   <= '0;
      stride_q <= '0;
      count_q  <= '0;
      width_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          RA_CTRL:      ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
          RA_BASE_LO:   base_q[7:0] <= wdata_i;
          RA_BASE_HI:   base_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
          RA_WIDTH:     width_q <= wdata_i[CNT_W-1:0];
          RA_STRIDE_LO: stride_q[7:0] <= wdata_i;
          RA_STRIDE_HI: stride_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
          default: ;
        endcase
      end
      if (done_set_i || err_set_i) ctrl_q.en <= 1'b0;
      if (step_i) count_q <= count_q - 1'b1;
      else if (we_i && addr_i == RA_COUNT) count_q <= wdata_i[CNT_W-1:0];
      if (done_set_i) done_q <= 1'b1;
      else if (rd_ctrl) done_q <= 1'b0;
      if (err_set_i) err_q <= 1'b1;
      else if (rd_ctrl) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL:      rdata_o = {1'b0, err_q, done_q, ctrl_q};
      RA_BASE_LO:   rdata_o = base_q[7:0];
      RA_BASE_HI:   rdata_o = REG_DW'(base_q[ADDR_W-1:8]);
      RA_COUNT:     rdata_o = REG_DW'(count_q);
      RA_WIDTH:     rdata_o = REG_DW'(width_q);
      RA_STRIDE_LO: rdata_o = stride_q[7:0];
      RA_STRIDE_HI: rdata_o = REG_DW'(stride_q[ADDR_W-1:8]);
      default:      rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign base_o    = base_q;
  assign stride_o  = stride_q;
  assign count_o   = count_q;
  assign width_o   = width_q;
  assign ptr_clr_o = we_i && (addr_i == RA_BASE_LO || addr_i == RA_BASE_HI);
  assign irq_o     = done_q || err_q;

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> count_q == CNT_W'($past(count_q) - 1'b1));
  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_ctrl) |=> irq_o);
  assert_en_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i || err_set_i) |=> !ctrl_q.en);
endmodule

// File: rtl/blit_dma_step.sv
module blit_dma_step #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              rect_i,
  input  logic              bank_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W:0]   addr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  col_q;
  logic              row_end;

  assign row_end = rect_i && (col_q == CNT_W'(width_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
      col_q <= '0;
    end else if (step_i) begin
      if (row_end) begin
        ptr_q <= ptr_q + stride_i;
        col_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign addr_o = {bank_i, base_i + ptr_q};

  assert_linear_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rect_i && !clr_i && $stable(base_i) && $stable(bank_i))
      |=> addr_o == ($past(addr_o) & {1'b1, {ADDR_W{1'b0}}}) + {1'b0, ADDR_W'($past(addr_o[ADDR_W-1:0]) + 1'b1)});
endmodule

// File: rtl/blit_dma_fsm.sv
module blit_dma_fsm
  import blit_dma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             gnt_i,
  input  logic             vid_full_i,
  input  logic             vid_empty_i,
  input  logic             ifc_full_i,
  input  logic             ifc_empty_i,
  output logic             mem_req_o,
  output logic             mem_en_o,
  output logic             mem_we_o,
  output logic             vid_push_o,
  output logic             vid_pop_o,
  output logic             ifc_push_o,
  output logic             ifc_pop_o,
  output logic             step_o,
  output logic             done_set_o,
  output logic             err_set_o
);
  state_t state_q, state_d;
  logic   blocked, move, last;

  assign blocked = dir_i ? (sel_i ? ifc_empty_i : vid_empty_i)
                         : (sel_i ? ifc_full_i  : vid_full_i);
  assign move    = (state_q == ST_MOVE) && gnt_i && !blocked;
  assign last    = (count_i == CNT_W'(1));

  assign err_set_o  = (state_q == ST_MOVE) && gnt_i && blocked;
  assign step_o     = (state_q == ST_UPDATE);
  assign done_set_o = ((state_q == ST_IDLE) && en_i && (count_i == '0)) ||
                      ((state_q == ST_UPDATE) && last);

  assign mem_req_o  = (state_q != ST_IDLE);
  assign mem_en_o   = move;
  assign mem_we_o   = move && dir_i;
  assign vid_push_o = move && !dir_i && !sel_i;
  assign ifc_push_o = move && !dir_i &&  sel_i;
  assign vid_pop_o  = move &&  dir_i && !sel_i;
  assign ifc_pop_o  = move &&  dir_i &&  sel_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (en_i && count_i != '0) state_d = ST_MOVE;
      ST_MOVE:   if (move) state_d = ST_UPDATE;
                 else if (err_set_o) state_d = ST_IDLE;
      ST_UPDATE: state_d = last ? ST_IDLE : ST_MOVE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_vid_push_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_push_o |-> !vid_full_i);
  assert_ifc_push_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifc_push_o |-> !ifc_full_i);
  assert_pop_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_pop_o |-> !vid_empty_i) and (ifc_pop_o |-> !ifc_empty_i));
  assert_gnt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (gnt_i && mem_req_o));
  assert_two_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> !mem_en_o);
  assert_strobe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vid_push_o, ifc_push_o, vid_pop_o, ifc_pop_o}));
endmodule

// File: rtl/blit_dma.sv
module blit_dma
  import blit_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_rd_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              vid_push_o,
  input  logic              vid_full_i,
  output logic              vid_pop_o,
  input  logic              vid_empty_i,
  input  logic [DATA_W-1:0] vid_rdata_i,
  output logic              ifc_push_o,
  input  logic              ifc_full_i,
  output logic              ifc_pop_o,
  input  logic              ifc_empty_i,
  input  logic [DATA_W-1:0] ifc_rdata_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base, stride;
  logic [CNT_W-1:0]  count, width;
  logic              ptr_clr, step, done_set, err_set;

  blit_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i), .rd_i(reg_rd_i),
    .step_i(step), .done_set_i(done_set), .err_set_i(err_set),
    .rdata_o(reg_rdata_o), .ctrl_o(ctrl), .base_o(base), .stride_o(stride),
    .count_o(count), .width_o(width), .ptr_clr_o(ptr_clr), .irq_o(irq_o)
  );

  blit_dma_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(ptr_clr || done_set), .step_i(step),
    .rect_i(ctrl.rect), .bank_i(ctrl.bank),
    .width_i(width), .stride_i(stride), .base_i(base),
    .addr_o(mem_addr_o)
  );

  blit_dma_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(ctrl.en), .dir_i(ctrl.dir), .sel_i(ctrl.sel), .count_i(count),
    .gnt_i(mem_gnt_i),
    .vid_full_i(vid_full_i), .vid_empty_i(vid_empty_i),
    .ifc_full_i(ifc_full_i), .ifc_empty_i(ifc_empty_i),
    .mem_req_o(mem_req_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .vid_push_o(vid_push_o), .vid_pop_o(vid_pop_o),
    .ifc_push_o(ifc_push_o), .ifc_pop_o(ifc_pop_o),
    .step_o(step), .done_set_o(done_set), .err_set_o(err_set)
  );

  assign fifo_wdata_o = mem_rdata_i;
  assign mem_wdata_o  = ctrl.sel ? ifc_rdata_i : vid_rdata_i;

  assert_done_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set |=> irq_o);
endmodule

// File: tb/blit_dma_tb.sv
module blit_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_gnt = 1'b1, mem_en, mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, fifo_wdata;
  logic        vid_push, vid_pop, ifc_push, ifc_pop;
  logic        vid_full = 1'b0, vid_empty = 1'b0, ifc_full = 1'b0, ifc_empty = 1'b0;
  logic [7:0]  vid_rdata = 8'hC0, ifc_rdata = 8'h00;
  logic        irq;

  int checks = 0, errors = 0, cyc = 0, n_log = 0;
  logic [1:0]  log_kind [LOG_N];  // 0 vid push, 1 ifc push, 2 mem write
  logic [16:0] log_addr [LOG_N];
  logic [7:0]  log_data [LOG_N];
  int          log_cyc  [LOG_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;

  blit_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_rd_i(reg_rd),
    .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .fifo_wdata_o(fifo_wdata),
    .vid_push_o(vid_push), .vid_full_i(vid_full), .vid_pop_o(vid_pop),
    .vid_empty_i(vid_empty), .vid_rdata_i(vid_rdata),
    .ifc_push_o(ifc_push), .ifc_full_i(ifc_full), .ifc_pop_o(ifc_pop),
    .ifc_empty_i(ifc_empty), .ifc_rdata_i(ifc_rdata),
    .irq_o(irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (n_log < LOG_N && (vid_push || ifc_push || (mem_en && mem_we))) begin
      log_kind[n_log] <= vid_push ? 2'd0 : (ifc_push ? 2'd1 : 2'd2);
      log_addr[n_log] <= mem_addr;
      log_data[n_log] <= vid_push || ifc_push ? fifo_wdata : mem_wdata;
      log_cyc[n_log]  <= cyc;
      n_log <= n_log + 1;
    end
    if (vid_pop) vid_rdata <= vid_rdata + 8'd1;
  end

  function automatic logic [7:0] mem_val(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(req, irq, 1'b1);
  endtask

  // Check n log entries starting at s: kind, linear address from a0, data from memory.
  task automatic chk_push_run(input string req, input int s, input int n,
                              input logic [1:0] kind, input logic [16:0] a0);
    chk(req, n_log - s, n);
    for (int i = 0; i < n; i++) begin
      chk(req, log_kind[s+i], kind);
      chk(req, log_addr[s+i], a0 + 17'(i));
      chk(req, log_data[s+i], mem_val(a0 + 17'(i)));
    end
  endtask

  // addr, wdata, expected read-back
  localparam logic [18:0] VEC [0:6] = '{
    {3'd1, 8'h34, 8'h34}, {3'd2, 8'h12, 8'h12}, {3'd3, 8'h04, 8'h04},
    {3'd4, 8'h03, 8'h03}, {3'd5, 8'h0A, 8'h0A}, {3'd6, 8'h5C, 8'h5C},
    {3'd0, 8'h1E, 8'h1E}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s;
    repeat (3) @(negedge clk);
    chk("R1 irq", irq, 1'b0);
    chk("R1 req", mem_req, 1'b0);
    chk("R1 strobes", {mem_en, vid_push, ifc_push, vid_pop, ifc_pop}, 5'd0);
    rst_n = 1'b1;
    for (int r = 0; r < 7; r++) begin
      rd(3'(r), d);
      chk("R1 reg zero", d, 8'h00);
    end

    // R2 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], d);
      chk("R2 readback", d, VEC[i][7:0]);
    end
    chk("R2 no irq", irq, 1'b0);

    // R3 linear memory to video FIFO
    wr(3'd1, 8'h00); wr(3'd2, 8'h12); wr(3'd3, 8'd4);
    s = n_log;
    wr(3'd0, 8'h01);
    wait_irq("R5 irq");
    chk_push_run("R3 linear", s, 4, 2'd0, 17'h01200);
    for (int i = 1; i < 4; i++) chk("R3 two clocks", log_cyc[s+i] - log_cyc[s+i-1], 2);
    rd(3'd3, d); chk("R5 count zero", d, 8'h00);
    rd(3'd0, d); chk("R5 done en clear", d, 8'h20);
    @(negedge clk);
    chk("R7 irq cleared", irq, 1'b0);
    rd(3'd0, d); chk("R7 flags cleared", d, 8'h00);

    // R12 pointer cleared at completion: same base starts again
    wr(3'd3, 8'd2);
    s = n_log;
    wr(3'd0, 8'h01);
    wait_irq("R12 irq");
    chk_push_run("R12 restart base", s, 2, 2'd0, 17'h01200);
    rd(3'd0, d);

    // R9 bank bit, interface FIFO
    wr(3'd1, 8'hF0); wr(3'd2, 8'h00); wr(3'd3, 8'd2);
    s = n_log;
    wr(3'd0, 8'h15);
    wait_irq("R9 irq");
    chk_push_run("R9 bank ifc", s, 2, 2'd1, 17'h100F0);
    rd(3'd0, d); chk("R9 status", d, 8'h34);

    // R4 FIFO to memory from video FIFO
    wr(3'd1, 8'h00); wr(3'd2, 8'h20); wr(3'd3, 8'd3);
    @(negedge clk); vid_rdata = 8'hC0;
    s = n_log;
    wr(3'd0, 8'h03);
    wait_irq("R4 irq");
    chk("R4 count", n_log - s, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 kind", log_kind[s+i], 2'd2);
      chk("R4 addr", log_addr[s+i], 17'h02000 + 17'(i));
      chk("R4 data", log_data[s+i], 8'hC0 + 8'(i));
    end
    rd(3'd0, d); chk("R4 status", d, 8'h22);

    // R6 abort on full, then resume
    wr(3'd1, 8'h00); wr(3'd2, 8'h30); wr(3'd3, 8'd5);
    s = n_log;
    wr(3'd0, 8'h01);
    while (n_log < s + 2) @(negedge clk);
    vid_full = 1'b1;
    wait_irq("R6 irq");
    repeat (4) @(negedge clk);
    chk("R6 pushes before abort", n_log - s, 2);
    chk("R6 req dropped", mem_req, 1'b0);
    rd(3'd3, d); chk("R6 count kept", d, 8'd3);
    rd(3'd0, d); chk("R6 err en clear", d, 8'h40);
    vid_full = 1'b0;
    s = n_log;
    wr(3'd0, 8'h01);
    wait_irq("R6 resume irq");
    chk_push_run("R6 resume", s, 3, 2'd0, 17'h03002);
    rd(3'd0, d); chk("R6 resume done", d, 8'h20);

    // R6 abort on empty interface FIFO
    ifc_empty = 1'b1;
    wr(3'd3, 8'd2);
    s = n_log;
    wr(3'd0, 8'h07);
    wait_irq("R6 empty irq");
    chk("R6 no write", n_log - s, 0);
    rd(3'd3, d); chk("R6 empty count", d, 8'd2);
    rd(3'd0, d); chk("R6 empty status", d, 8'h46);
    ifc_empty = 1'b0;

    // R8 rectangle: width 3, stride 10
    wr(3'd1, 8'h00); wr(3'd2, 8'h40); wr(3'd3, 8'd7);
    wr(3'd4, 8'd3); wr(3'd5, 8'd10); wr(3'd6, 8'd0);
    s = n_log;
    wr(3'd0, 8'h09);
    wait_irq("R8 irq");
    chk("R8 count", n_log - s, 7);
    begin
      logic [16:0] ex [7] = '{17'h04000, 17'h04001, 17'h04002, 17'h0400C,
                              17'h0400D, 17'h0400E, 17'h04018};
      for (int i = 0; i < 7; i++) begin
        chk("R8 addr", log_addr[s+i], ex[i]);
        chk("R8 data", log_data[s+i], mem_val(ex[i]));
      end
    end
    rd(3'd0, d); chk("R8 status", d, 8'h28);

    // R10 no access without grant
    mem_gnt = 1'b0;
    wr(3'd1, 8'h00); wr(3'd2, 8'h50); wr(3'd3, 8'd2);
    s = n_log;
    wr(3'd0, 8'h01);
    repeat (10) @(negedge clk);
    chk("R10 req held", mem_req, 1'b1);
    chk("R10 no access", n_log - s, 0);
    chk("R10 no irq", irq, 1'b0);
    mem_gnt = 1'b1;
    wait_irq("R10 irq");
    chk_push_run("R10 after grant", s, 2, 2'd0, 17'h05000);
    rd(3'd0, d);

    // R11 zero count
    wr(3'd3, 8'd0);
    s = n_log;
    wr(3'd0, 8'h01);
    wait_irq("R11 irq");
    chk("R11 no access", n_log - s, 0);
    rd(3'd0, d); chk("R11 status", d, 8'h20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule